// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block is the combinational hazard controller of a five-stage in-order pipeline with eight general registers, each named by a 3-bit register number. For each of the two ALU operands, it compares the operand's source register number in the execute stage with the destination numbers and write enables of the two later stages. From that comparison it picks where the operand comes from: the register file, the result leaving the execute stage, or the result leaving the memory stage. Write-back in the same cycle needs no path, because the register file writes early in the cycle and reads late.

The block also watches the instruction in decode. When the execute stage holds a load whose destination is a source of that instruction, the block requests a single-cycle stall. The program counter and the fetch/decode register hold, and a bubble enters the decode/execute register. After the stall, the forwarding path from the memory stage delivers the loaded word. Branches are predicted not taken. When a branch resolves taken in execute, the block issues the redirect and clears the two younger pipeline registers in the same cycle. The flush takes precedence over any stall request.

Top module: `hazard_unit`

## Requirements
- R1: An operand select reads 1 (execute-stage result) when the execute/memory register has its write enable set and its destination equals that operand's source number.
- R2: An operand select reads 2 (memory-stage result) when the memory/write-back register has its write enable set and its destination matches, and the execute/memory register does not supply that operand.
- R3: When both later stages write the operand's source register, the select reads 1, so the younger result wins.
- R4: An operand select reads 0 (register file) when no enabled producer matches. A producer whose write enable is low is never forwarded, even when its destination number matches.
- R5: Operand A is judged only on `ex_rs_a` and operand B only on `ex_rs_b`, so the two selects can differ within one cycle.
- R6: When `ex_mem_read` is high and `ex_rd` equals `id_rs_a` or `id_rs_b`, the outputs `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R7: When `ex_mem_read` is low, a matching `ex_rd` causes no stall: `pc_hold`, `ifid_hold` and `idex_bubble` are all 0.
- R8: When `br_taken` is high, `pc_redirect`, `ifid_flush` and `idex_flush` are all 1.
- R9: A taken branch cancels a load-use stall. With `br_taken` high, `pc_hold`, `ifid_hold` and `idex_bubble` are 0.
- R10: With no load-use match and no taken branch, all six pipeline control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_a | input | 3 | Source register number of operand A in execute |
| ex_rs_b | input | 3 | Source register number of operand B in execute |
| exm_reg_write | input | 1 | Write enable held in the execute/memory register |
| exm_rd | input | 3 | Destination number held in the execute/memory register |
| mwb_reg_write | input | 1 | Write enable held in the memory/write-back register |
| mwb_rd | input | 3 | Destination number held in the memory/write-back register |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_rd | input | 3 | Destination number of the instruction in execute |
| id_rs_a | input | 3 | First source number of the instruction in decode |
| id_rs_b | input | 3 | Second source number of the instruction in decode |
| br_taken | input | 1 | Branch in execute resolved taken |
| fwd_sel_a | output | 2 | Operand A source: 0 register file, 1 execute result, 2 memory result |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ifid_flush | output | 1 | Clear the fetch/decode register to a no-op |
| idex_flush | output | 1 | Clear the decode/execute register to a no-op |
| pc_redirect | output | 1 | Steer fetch to the resolved branch target |

## Verification
The forwarding selects are tried with several kinds of pattern. In some, only one stage matches, which separates the two forwarding paths. In others, both stages name the same register, which exposes the priority order. Some give matching numbers with the write enable low, which shows whether the enable gates the comparison. Others give different sources to the two operands in one cycle, which would reveal crossed wiring. The stall logic is driven in several ways: a load matching the first source, a load matching the second source, a non-load with the same destination, and a load with no match. This separates the load qualifier from the register comparison. A load-use match combined with a taken branch shows that the flush overrides the stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_REG = 2'd0,
    FWD_EXM = 2'd1,
    FWD_MWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
  parameter int unsigned AW = 3
) (
  input  logic [AW-1:0]    src,
  input  logic             exm_we,
  input  logic [AW-1:0]    exm_rd,
  input  logic             mwb_we,
  input  logic [AW-1:0]    mwb_rd,
  output hz_pkg::fwd_sel_e sel,
  output logic             exm_hit,
  output logic             mwb_hit
);
  function automatic logic producer_hits(input logic we, input logic [AW-1:0] rd,
                                         input logic [AW-1:0] s);
    return we && (rd == s);
  endfunction

  assign exm_hit = producer_hits(exm_we, exm_rd, src);
  assign mwb_hit = producer_hits(mwb_we, mwb_rd, src);

  always_comb begin
    if (exm_hit)      sel = hz_pkg::FWD_EXM;
    else if (mwb_hit) sel = hz_pkg::FWD_MWB;
    else              sel = hz_pkg::FWD_REG;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW   = 3,
  parameter int unsigned NSRC = 2
) (
  input  logic                     ld_in_ex,
  input  logic [AW-1:0]            ld_rd,
  input  logic [NSRC-1:0][AW-1:0]  dec_src,
  output logic                     hit
);
  logic [NSRC-1:0] src_match;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_match[i] = (dec_src[i] == ld_rd);
  end

  assign hit = ld_in_ex && (|src_match);
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic taken,
  input  logic stall_req,
  output logic pc_hold,
  output logic ifid_hold,
  output logic idex_bubble,
  output logic ifid_flush,
  output logic idex_flush,
  output logic pc_redirect
);
  logic stall_eff;

  assign stall_eff   = stall_req && !taken;
  assign pc_hold     = stall_eff;
  assign ifid_hold   = stall_eff;
  assign idex_bubble = stall_eff;
  assign ifid_flush  = taken;
  assign idex_flush  = taken;
  assign pc_redirect = taken;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned NOPND = 2,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic [AW-1:0] ex_rs_a,
  input  logic [AW-1:0] ex_rs_b,
  input  logic          exm_reg_write,
  input  logic [AW-1:0] exm_rd,
  input  logic          mwb_reg_write,
  input  logic [AW-1:0] mwb_rd,
  input  logic          ex_mem_read,
  input  logic [AW-1:0] ex_rd,
  input  logic [AW-1:0] id_rs_a,
  input  logic [AW-1:0] id_rs_b,
  input  logic          br_taken,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush,
  output logic          idex_flush,
  output logic          pc_redirect
);
  logic [NOPND-1:0][AW-1:0] ex_src;
  logic [NOPND-1:0][AW-1:0] id_src;
  hz_pkg::fwd_sel_e         opnd_sel [NOPND];
  logic [NOPND-1:0]         exm_hit_v;
  logic [NOPND-1:0]         mwb_hit_v;
  logic                     load_use_hit;

  assign ex_src[0] = ex_rs_a;
  assign ex_src[1] = ex_rs_b;
  assign id_src[0] = id_rs_a;
  assign id_src[1] = id_rs_b;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    hz_fwd_pick #(.AW(AW)) u_pick (
      .src     (ex_src[k]),
      .exm_we  (exm_reg_write),
      .exm_rd  (exm_rd),
      .mwb_we  (mwb_reg_write),
      .mwb_rd  (mwb_rd),
      .sel     (opnd_sel[k]),
      .exm_hit (exm_hit_v[k]),
      .mwb_hit (mwb_hit_v[k])
    );
  end

  assign fwd_sel_a = opnd_sel[0];
  assign fwd_sel_b = opnd_sel[1];

  hz_load_use #(.AW(AW), .NSRC(NOPND)) u_lu (
    .ld_in_ex (ex_mem_read),
    .ld_rd    (ex_rd),
    .dec_src  (id_src),
    .hit      (load_use_hit)
  );

  hz_redirect u_redir (
    .taken       (br_taken),
    .stall_req   (load_use_hit),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush),
    .idex_flush  (idex_flush),
    .pc_redirect (pc_redirect)
  );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned AW = 3
) (
  input logic [AW-1:0] ex_rs_a,
  input logic [AW-1:0] ex_rs_b,
  input logic          exm_reg_write,
  input logic [AW-1:0] exm_rd,
  input logic          mwb_reg_write,
  input logic [AW-1:0] mwb_rd,
  input logic          br_taken,
  input logic          load_use_hit,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          idex_bubble,
  input logic          ifid_flush,
  input logic          idex_flush,
  input logic          pc_redirect
);
  always_comb begin
    // R3: younger producer wins on operand A
    if (exm_reg_write && exm_rd == ex_rs_a)
      p_exm_prio_r3: assert (fwd_sel_a == 2'd1);
    // R4: memory-stage path on B only with an enabled matching producer
    if (fwd_sel_b == 2'd2)
      p_mwb_qual_r4: assert (mwb_reg_write && mwb_rd == ex_rs_b);
    // R5: no select takes the unused code
    p_sel_legal_r5: assert (fwd_sel_a != 2'd3 && fwd_sel_b != 2'd3);
    // R6: stall outputs move together and follow the load-use detector
    p_stall_group_r6: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
    if (load_use_hit && !br_taken)
      p_stall_on_hit_r6: assert (pc_hold);
    // R9: flush overrides stall
    if (br_taken)
      p_flush_wins_r9: assert (!pc_hold && ifid_flush && idex_flush && pc_redirect);
  end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (
  .ex_rs_a       (ex_rs_a),
  .ex_rs_b       (ex_rs_b),
  .exm_reg_write (exm_reg_write),
  .exm_rd        (exm_rd),
  .mwb_reg_write (mwb_reg_write),
  .mwb_rd        (mwb_rd),
  .br_taken      (br_taken),
  .load_use_hit  (load_use_hit),
  .fwd_sel_a     (fwd_sel_a),
  .fwd_sel_b     (fwd_sel_b),
  .pc_hold       (pc_hold),
  .ifid_hold     (ifid_hold),
  .idex_bubble   (idex_bubble),
  .ifid_flush    (ifid_flush),
  .idex_flush    (idex_flush),
  .pc_redirect   (pc_redirect)
);

// File: tb/sim_hazard_unit.sv
`timescale 1ns/1ps
module sim_hazard_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] ex_rs_a, ex_rs_b, exm_rd, mwb_rd, ex_rd, id_rs_a, id_rs_b;
  logic exm_reg_write, mwb_reg_write, ex_mem_read, br_taken;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush, pc_redirect;

  int n_chk = 0;
  int n_bad = 0;

  hazard_unit u0 (.*);

  // {exm_we, exm_rd, mwb_we, mwb_rd, rs_a, rs_b, exp_a, exp_b}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 3'd3, 1'b0, 3'd3, 3'd3, 3'd5, 2'd1, 2'd0},  // R1
    {1'b0, 3'd5, 1'b1, 3'd5, 3'd5, 3'd5, 2'd2, 2'd2},  // R2
    {1'b1, 3'd4, 1'b1, 3'd4, 3'd4, 3'd4, 2'd1, 2'd1},  // R3
    {1'b0, 3'd2, 1'b0, 3'd2, 3'd2, 3'd2, 2'd0, 2'd0},  // R4
    {1'b1, 3'd6, 1'b1, 3'd1, 3'd1, 3'd6, 2'd2, 2'd1},  // R5
    {1'b1, 3'd0, 1'b1, 3'd7, 3'd7, 3'd0, 2'd2, 2'd1},  // R5
    {1'b1, 3'd7, 1'b1, 3'd7, 3'd3, 3'd2, 2'd0, 2'd0},  // R4
    {1'b1, 3'd2, 1'b0, 3'd2, 3'd0, 3'd2, 2'd0, 2'd1}   // R1
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ctl();
    return {pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush, pc_redirect};
  endfunction

  task automatic set_ctl(input logic ld, input logic [2:0] rd, input logic [2:0] a,
                         input logic [2:0] b, input logic tk);
    @(negedge clk);
    ex_mem_read = ld; ex_rd = rd; id_rs_a = a; id_rs_b = b; br_taken = tk;
    #1;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    {ex_rs_a, ex_rs_b, exm_rd, mwb_rd, ex_rd, id_rs_a, id_rs_b} = '0;
    {exm_reg_write, mwb_reg_write, ex_mem_read, br_taken} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 idle", ctl(), 6'b000000);
    chk("R4 idle sel", {2'b00, fwd_sel_a, fwd_sel_b}, 6'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {exm_reg_write, exm_rd, mwb_reg_write, mwb_rd, ex_rs_a, ex_rs_b} = VEC[i][17:4];
      #1;
      chk($sformatf("R1-5 vec%0d opA", i), {4'b0, fwd_sel_a}, {4'b0, VEC[i][3:2]});
      chk($sformatf("R1-5 vec%0d opB", i), {4'b0, fwd_sel_b}, {4'b0, VEC[i][1:0]});
    end

    // R6: load hits first source, then second source
    set_ctl(1'b1, 3'd4, 3'd4, 3'd1, 1'b0);
    chk("R6 src a", ctl(), 6'b111000);
    set_ctl(1'b1, 3'd6, 3'd2, 3'd6, 1'b0);
    chk("R6 src b", ctl(), 6'b111000);
    // R7: non-load with matching destination
    set_ctl(1'b0, 3'd6, 3'd6, 3'd6, 1'b0);
    chk("R7 no load", ctl(), 6'b000000);
    // R10: load without match
    set_ctl(1'b1, 3'd5, 3'd0, 3'd7, 1'b0);
    chk("R10 load no match", ctl(), 6'b000000);
    // R8: taken branch alone
    set_ctl(1'b0, 3'd0, 3'd1, 3'd2, 1'b1);
    chk("R8 taken", ctl(), 6'b000111);
    // R9: taken branch with load-use match
    set_ctl(1'b1, 3'd3, 3'd3, 3'd3, 1'b1);
    chk("R9 flush wins", ctl(), 6'b000111);
    // R6 again after branch drops
    set_ctl(1'b1, 3'd3, 3'd3, 3'd3, 1'b0);
    chk("R6 after flush", ctl(), 6'b111000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule